// File: doc/BRIEF.md
# Error-Correcting Configuration Register Bank

This block holds a bank of byte-addressed configuration registers. Each register drives its value straight onto a wide output bus, where analog bias circuits and pixel-matrix row and column controls consume it. Software writes and reads the registers over a Wishbone classic slave port. Each register sits in one slot of the bank, and each slot is stored as two 8-bit code words, one for each 4-bit half. A code word holds a Hamming(7,4) code plus an overall parity bit. As a result, one upset bit in any code word is corrected before it reaches the outputs or the read path, and two upset bits are detected.

Two flags report upsets across the whole bank. `err_single` is the OR of every correctable error, and `err_multi` is the OR of every uncorrectable error. A one-cycle `refresh` pulse scrubs the bank: it writes the corrected code words back into storage. A one-cycle `ldinit` pulse loads a fixed set of power-on defaults. Slot 0 is unused. Slots 1 to 10 hold 6-bit bias settings. Slots 11 to 30 each pack two 4-bit row fields. Slots 31 to 90 hold 7-bit column settings.

Top module: `cfg_secded_bank`

## Requirements
- R1: While `rst` is high at a rising clock edge, every code word is cleared. From the next cycle, `cfg_o` is all zero, both error flags are low and `wb_ack` is low.
- R2: A request cycle is a cycle with `wb_cyc` and `wb_stb` high while `wb_ack` is low. The edge of a request cycle raises `wb_ack` for exactly one cycle. If `wb_we` is high, that edge also stores `wb_dat_i` ANDed with the slot's width mask. The width mask is 0x3F for slots 1–10, 0xFF for slots 11–30 and 0x7F for slots 31–90. The new value appears on `cfg_o` in the cycle where `wb_ack` is high.
- R3: A read request puts the corrected, masked value of the addressed slot on `wb_dat_o` while `wb_ack` is high. The bits above the slot's width read as zero.
- R4: A write to address 0, or to any address above 90, is acknowledged and changes no output. A read from such an address returns 0x00.
- R5: `ldinit` high at an edge loads the defaults and takes priority over a Wishbone write in the same cycle. The defaults for slots 1..9 are 0x13, 0x24, 0x32, 0x26, 0x2D, 0x12, 0x26, 0x25, 0x15. Every other slot defaults to 0x00.
- R6: Code word bit k holds Hamming position k. Bit 0 is overall parity, bits 1, 2 and 4 are check bits, and data bits d0..d3 sit at bits 3, 5, 6 and 7. Slot bits [7:0] hold the low half and bits [15:8] the high half. One flipped bit at any position leaves `cfg_o` and reads correct, raises `err_single` and leaves `err_multi` low.
- R7: Two flipped bits in one code word raise `err_multi` without raising `err_single`. A later Wishbone write to that slot clears the condition.
- R8: The two flags are ORs over all code words, so upsets in different slots can raise both flags together.
- R9: A `refresh` pulse writes every correctable code word back in corrected form, which clears `err_single`. Words with a double error keep their state.
- R10: Byte k of `cfg_o` (bits 8k+7..8k) carries slot k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the bank |
| ldinit | input | 1 | Synchronous load of default values |
| refresh | input | 1 | Write corrected code words back to storage |
| wb_cyc | input | 1 | Wishbone bus cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_adr | input | 7 | Wishbone register address |
| wb_dat_i | input | 8 | Wishbone write data |
| wb_dat_o | output | 8 | Wishbone read data, corrected |
| wb_ack | output | 1 | Wishbone acknowledge, one cycle |
| cfg_o | output | 728 | Corrected register values, byte k is slot k |
| err_single | output | 1 | A correctable upset is present somewhere in the bank |
| err_multi | output | 1 | An uncorrectable upset is present somewhere in the bank |

## Verification
The assertions check the following on every cycle:
- The acknowledge lasts one cycle and follows only requests.
- The bank comes out of reset empty.
- A bias write lands on the output bus masked to six bits.
- A default load produces its fixed value.
- A refresh with no double errors leaves `err_single` low.

The bench scenarios cover what needs a deliberate upset in storage. It flips chosen code-word bits at every one of the eight positions and checks correction, the flags, the write-back by refresh and the recovery from double errors. Random mixes of reads, writes and upsets compare the whole output bus and every read against a model of the bank.

// File: rtl/cfg_secded_pkg.sv
package cfg_secded_pkg;

    localparam int BYTE_W  = 8;
    localparam int NIB_W   = 4;
    localparam int CODE_W  = 8;
    localparam int N_BIAS  = 10;
    localparam int N_ROWPR = 20;
    localparam int N_COL   = 60;
    localparam int BIAS_LO = 1;
    localparam int ROW_LO  = BIAS_LO + N_BIAS;
    localparam int COL_LO  = ROW_LO + N_ROWPR;
    localparam int N_SLOT  = COL_LO + N_COL;
    localparam int SLOT_CW = 2 * CODE_W;
    localparam int IDX_W   = $clog2(N_SLOT);

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t hi;
        code_t lo;
    } slot_code_t;

    typedef struct packed {
        logic [NIB_W-1:0] data;
        code_t            fixed;
        logic             single;
        logic             multi;
    } nib_dec_t;

    // Hamming(7,4) in positions 1..7, overall parity in position 0
    function automatic code_t secded_enc(input logic [NIB_W-1:0] d);
        code_t c;
        c[3] = d[0];
        c[5] = d[1];
        c[6] = d[2];
        c[7] = d[3];
        c[1] = d[0] ^ d[1] ^ d[3];
        c[2] = d[0] ^ d[2] ^ d[3];
        c[4] = d[1] ^ d[2] ^ d[3];
        c[0] = ^c[7:1];
        return c;
    endfunction

    function automatic slot_code_t slot_enc(input logic [BYTE_W-1:0] b);
        slot_code_t s;
        s.hi = secded_enc(b[7:4]);
        s.lo = secded_enc(b[3:0]);
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] slot_mask(input int unsigned a);
        if (a >= BIAS_LO && a < ROW_LO)      return 8'h3F;
        else if (a >= ROW_LO && a < COL_LO)  return 8'hFF;
        else if (a >= COL_LO && a < N_SLOT)  return 8'h7F;
        else                                 return 8'h00;
    endfunction

    function automatic logic [BYTE_W-1:0] slot_default(input int unsigned a);
        case (a)
            1:       return 8'h13;
            2:       return 8'h24;
            3:       return 8'h32;
            4:       return 8'h26;
            5:       return 8'h2D;
            6:       return 8'h12;
            7:       return 8'h26;
            8:       return 8'h25;
            9:       return 8'h15;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_nib_dec.sv
module cfg_nib_dec
    import cfg_secded_pkg::*;
(
    input  code_t    cw,
    output nib_dec_t res
);
    logic [2:0] syn;
    logic       par_err;
    code_t      flip;

    always_comb begin
        syn[0]  = cw[1] ^ cw[3] ^ cw[5] ^ cw[7];
        syn[1]  = cw[2] ^ cw[3] ^ cw[6] ^ cw[7];
        syn[2]  = cw[4] ^ cw[5] ^ cw[6] ^ cw[7];
        par_err = ^cw;
        flip    = par_err ? (code_t'(1) << syn) : '0;
        res.fixed  = cw ^ flip;
        res.data   = {res.fixed[7], res.fixed[6], res.fixed[5], res.fixed[3]};
        res.single = par_err;
        res.multi  = (syn != 3'd0) && !par_err;
    end
endmodule

// File: rtl/cfg_code_store.sv
module cfg_code_store
    import cfg_secded_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ldinit,
    input  logic                      refresh,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [BYTE_W-1:0]         wr_byte,
    input  logic [N_SLOT*SLOT_CW-1:0] fixed_i,
    input  logic [2*N_SLOT-1:0]       multi_i,
    output logic [N_SLOT*SLOT_CW-1:0] code_q
);
    slot_code_t wr_code;

    always_comb wr_code = slot_enc(wr_byte);

    always_ff @(posedge clk) begin
        for (int k = 0; k < N_SLOT; k++) begin
            if (rst) begin
                code_q[k*SLOT_CW +: SLOT_CW] <= '0;
            end else if (ldinit) begin
                code_q[k*SLOT_CW +: SLOT_CW] <= slot_enc(slot_default(k) & slot_mask(k));
            end else if (wr_en && int'(wr_idx) == k) begin
                code_q[k*SLOT_CW +: SLOT_CW] <= wr_code;
            end else if (refresh) begin
                for (int h = 0; h < 2; h++) begin
                    if (!multi_i[2*k+h])
                        code_q[k*SLOT_CW + h*CODE_W +: CODE_W] <=
                            fixed_i[k*SLOT_CW + h*CODE_W +: CODE_W];
                end
            end
        end
    end
endmodule

// File: rtl/cfg_wb_port.sv
module cfg_wb_port
    import cfg_secded_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wb_cyc,
    input  logic                     wb_stb,
    input  logic                     wb_we,
    input  logic [ADDR_W-1:0]        wb_adr,
    input  logic [BYTE_W-1:0]        wb_dat_i,
    input  logic [N_SLOT*BYTE_W-1:0] rd_bus,
    output logic [BYTE_W-1:0]        wb_dat_o,
    output logic                     wb_ack,
    output logic                     wr_en,
    output logic [IDX_W-1:0]         wr_idx,
    output logic [BYTE_W-1:0]        wr_byte
);
    logic req, hit;

    always_comb begin
        req     = wb_cyc && wb_stb && !wb_ack;
        hit     = slot_mask(int'(wb_adr)) != '0;
        wr_en   = req && wb_we && hit;
        wr_idx  = IDX_W'(wb_adr);
        wr_byte = wb_dat_i & slot_mask(int'(wb_adr));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_ack   <= 1'b0;
            wb_dat_o <= '0;
        end else begin
            wb_ack <= req;
            if (req && !wb_we)
                wb_dat_o <= hit ? rd_bus[int'(wb_adr)*BYTE_W +: BYTE_W] : '0;
        end
    end
endmodule

// File: rtl/cfg_secded_bank.sv
module cfg_secded_bank
    import cfg_secded_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int CFG_W = N_SLOT * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ldinit,
    input  logic              refresh,
    input  logic              wb_cyc,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [ADDR_W-1:0] wb_adr,
    input  logic [7:0]        wb_dat_i,
    output logic [7:0]        wb_dat_o,
    output logic              wb_ack,
    output logic [CFG_W-1:0]  cfg_o,
    output logic              err_single,
    output logic              err_multi
);
    logic [N_SLOT*SLOT_CW-1:0] code_q;
    logic [N_SLOT*SLOT_CW-1:0] fixed_w;
    logic [2*N_SLOT-1:0]       single_w;
    logic [2*N_SLOT-1:0]       multi_w;
    logic                      wr_en;
    logic [IDX_W-1:0]          wr_idx;
    logic [BYTE_W-1:0]         wr_byte;

    for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
        nib_dec_t dec [2];
        for (genvar h = 0; h < 2; h++) begin : g_half
            cfg_nib_dec u_dec (
                .cw  (code_q[k*SLOT_CW + h*CODE_W +: CODE_W]),
                .res (dec[h])
            );
            assign fixed_w[k*SLOT_CW + h*CODE_W +: CODE_W] = dec[h].fixed;
            assign single_w[2*k+h] = dec[h].single;
            assign multi_w[2*k+h]  = dec[h].multi;
        end
        assign cfg_o[k*BYTE_W +: BYTE_W] = {dec[1].data, dec[0].data} & slot_mask(k);
    end

    assign err_single = |single_w;
    assign err_multi  = |multi_w;

    cfg_code_store u_store (
        .clk     (clk),
        .rst     (rst),
        .ldinit  (ldinit),
        .refresh (refresh),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_byte (wr_byte),
        .fixed_i (fixed_w),
        .multi_i (multi_w),
        .code_q  (code_q)
    );

    cfg_wb_port #(.ADDR_W(ADDR_W)) u_wb (
        .clk      (clk),
        .rst      (rst),
        .wb_cyc   (wb_cyc),
        .wb_stb   (wb_stb),
        .wb_we    (wb_we),
        .wb_adr   (wb_adr),
        .wb_dat_i (wb_dat_i),
        .rd_bus   (cfg_o),
        .wb_dat_o (wb_dat_o),
        .wb_ack   (wb_ack),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_byte  (wr_byte)
    );
endmodule

// File: rtl/cfg_secded_bank_chk.sv
module cfg_secded_bank_chk
    import cfg_secded_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     ldinit,
    input logic                     refresh,
    input logic                     wb_cyc,
    input logic                     wb_stb,
    input logic                     wb_we,
    input logic [ADDR_W-1:0]        wb_adr,
    input logic [7:0]               wb_dat_i,
    input logic                     wb_ack,
    input logic [N_SLOT*BYTE_W-1:0] cfg_o,
    input logic                     err_single,
    input logic                     err_multi
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg_o == '0 && !err_single && !err_multi && !wb_ack));

    // R2
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        wb_ack |=> !wb_ack);

    // R2
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        !(wb_cyc && wb_stb) |=> !wb_ack);

    // R2
    bias_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc && wb_stb && wb_we && !wb_ack && !ldinit && wb_adr == ADDR_W'(1))
        |=> cfg_o[15:8] == ($past(wb_dat_i) & 8'h3F));

    // R5
    default_load_chk: assert property (@(posedge clk) disable iff (rst)
        ldinit |=> cfg_o[15:8] == 8'h13 && cfg_o[23:16] == 8'h24);

    // R9
    refresh_scrub_chk: assert property (@(posedge clk) disable iff (rst)
        (refresh && !err_multi) |=> !err_single);
endmodule

bind cfg_secded_bank cfg_secded_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ldinit     (ldinit),
    .refresh    (refresh),
    .wb_cyc     (wb_cyc),
    .wb_stb     (wb_stb),
    .wb_we      (wb_we),
    .wb_adr     (wb_adr),
    .wb_dat_i   (wb_dat_i),
    .wb_ack     (wb_ack),
    .cfg_o      (cfg_o),
    .err_single (err_single),
    .err_multi  (err_multi)
);

// File: tb/cfg_secded_bank_bench.sv
module cfg_secded_bank_bench;
    import cfg_secded_pkg::*;

    localparam int CW = N_SLOT * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ldinit = 1'b0;
    logic          refresh = 1'b0;
    logic          wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
    logic [6:0]    wb_adr = '0;
    logic [7:0]    wb_dat_i = '0;
    logic [7:0]    wb_dat_o;
    logic          wb_ack;
    logic [CW-1:0] cfg_o;
    logic          err_single, err_multi;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    logic [7:0]  mdl_val  [N_SLOT];
    logic [15:0] mdl_code [N_SLOT];

    always #10 clk = ~clk;

    cfg_secded_bank u_cfg_secded_bank (
        .clk(clk), .rst(rst), .ldinit(ldinit), .refresh(refresh),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack(wb_ack),
        .cfg_o(cfg_o), .err_single(err_single), .err_multi(err_multi)
    );

    function automatic logic [7:0] b_enc(input logic [3:0] d);
        logic [7:0] c;
        c = '0;
        c[3] = d[0]; c[5] = d[1]; c[6] = d[2]; c[7] = d[3];
        c[1] = c[3] ^ c[5] ^ c[7];
        c[2] = c[3] ^ c[6] ^ c[7];
        c[4] = c[5] ^ c[6] ^ c[7];
        c[0] = c[1] ^ c[2] ^ c[3] ^ c[4] ^ c[5] ^ c[6] ^ c[7];
        return c;
    endfunction

    function automatic logic [7:0] b_mask(input int a);
        if (a >= 1 && a <= 10)  return 8'h3F;
        if (a >= 11 && a <= 30) return 8'hFF;
        if (a >= 31 && a <= 90) return 8'h7F;
        return 8'h00;
    endfunction

    function automatic logic [7:0] b_dflt(input int a);
        logic [7:0] t [10] = '{8'h00, 8'h13, 8'h24, 8'h32, 8'h26,
                               8'h2D, 8'h12, 8'h26, 8'h25, 8'h15};
        return (a < 10) ? t[a] : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mdl_set(input int a, input logic [7:0] v);
        mdl_val[a]  = v;
        mdl_code[a] = {b_enc(v[7:4]), b_enc(v[3:0])};
    endtask

    task automatic check_bus(input string req);
        int bad;
        bad = -1;
        for (int k = N_SLOT - 1; k >= 0; k--)
            if (cfg_o[k*8 +: 8] !== mdl_val[k]) bad = k;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, {bad[15:0], 8'h0, cfg_o[bad*8 +: 8]},
                 {bad[15:0], 8'h0, mdl_val[bad]});
    endtask

    task automatic wb_write(input int a, input logic [7:0] v);
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = 7'(a); wb_dat_i = v;
        @(negedge clk);
        chk(wb_ack === 1'b1, "R2 write ack", 32'(wb_ack), 1);
        wb_cyc = 0; wb_stb = 0; wb_we = 0;
        if (b_mask(a) != 0) mdl_set(a, v & b_mask(a));
    endtask

    task automatic wb_read(input int a, input string req);
        logic [7:0] exp;
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = 7'(a);
        @(negedge clk);
        exp = (a < N_SLOT) ? mdl_val[a] : 8'h00;
        chk(wb_ack === 1'b1 && wb_dat_o === exp, req, {23'd0, wb_ack, wb_dat_o},
            {24'd1, exp});
        wb_cyc = 0; wb_stb = 0;
    endtask

    task automatic push_code();
        logic [N_SLOT*16-1:0] v;
        for (int k = 0; k < N_SLOT; k++) v[k*16 +: 16] = mdl_code[k];
        force u_cfg_secded_bank.u_store.code_q = v;
        #1;
        release u_cfg_secded_bank.u_store.code_q;
        #1;
    endtask

    task automatic flip(input int a, input int bitpos);
        mdl_code[a][bitpos] = ~mdl_code[a][bitpos];
    endtask

    task automatic do_refresh();
        @(negedge clk);
        refresh = 1;
        @(negedge clk);
        refresh = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < N_SLOT; k++) mdl_set(k, 8'h00);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(cfg_o == '0, "R1 bus zero", 32'(cfg_o[31:0]), 0);
        chk(!err_single && !err_multi && !wb_ack, "R1 flags",
            {err_single, err_multi, wb_ack}, 0);

        // R5 defaults, priority over a simultaneous write to slot 2
        @(negedge clk);
        ldinit = 1; wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = 7'd2; wb_dat_i = 8'hFF;
        @(negedge clk);
        ldinit = 0; wb_cyc = 0; wb_stb = 0; wb_we = 0;
        for (int k = 0; k < N_SLOT; k++) mdl_set(k, b_dflt(k));
        chk(cfg_o[23:16] === 8'h24, "R5 ldinit beats write", 32'(cfg_o[23:16]), 32'h24);
        check_bus("R5 defaults R10");

        // R2 R3 masking per slot class
        wb_write(1, 8'hFF);   wb_read(1, "R3 bias read masked");
        wb_write(11, 8'hA5);  wb_read(11, "R3 row read");
        wb_write(90, 8'hFF);  wb_read(90, "R3 column read masked");
        check_bus("R2 bus after writes R10");

        // R4 unused and out-of-range addresses
        wb_write(0, 8'hFF);   wb_read(0, "R4 slot0 read zero");
        wb_write(100, 8'h5A); wb_read(100, "R4 out-of-range read zero");
        wb_write(127, 8'hFF);
        check_bus("R4 bus unchanged");

        // R6 single upset at every position, then R9 scrub
        wb_write(45, 8'h5A);
        for (int b = 0; b < 16; b++) begin
            @(negedge clk);
            flip(45, b);
            push_code();
            check_bus("R6 corrected output");
            chk(err_single && !err_multi, "R6 flags", {err_single, err_multi}, 2'b10);
            wb_read(45, "R6 corrected read");
            do_refresh();
            mdl_set(45, mdl_val[45]);
            chk(!err_single, "R9 scrub clears", 32'(err_single), 0);
        end

        // R7 double upset, R8 combined flags, R9 leaves double untouched
        wb_write(20, 8'hC3);
        @(negedge clk);
        flip(20, 9); flip(20, 14);
        push_code();
        chk(err_multi && !err_single, "R7 double flags", {err_single, err_multi}, 2'b01);
        flip(60, 3);
        push_code();
        chk(err_multi && err_single, "R8 both flags", {err_single, err_multi}, 2'b11);
        chk(cfg_o[60*8 +: 8] === mdl_val[60], "R8 other slot corrected",
            32'(cfg_o[60*8 +: 8]), 32'(mdl_val[60]));
        do_refresh();
        mdl_set(60, mdl_val[60]);
        chk(!err_single && err_multi, "R9 double kept", {err_single, err_multi}, 2'b01);
        wb_write(20, 8'h3C);
        @(negedge clk);
        chk(!err_multi, "R7 write clears double", 32'(err_multi), 0);
        check_bus("R7 bus restored");

        // Random traffic with occasional single upsets
        for (int i = 0; i < 400; i++) begin
            int a;
            a = int'($urandom_range(0, 127));
            if ($urandom_range(0, 1) == 1) wb_write(a, 8'($urandom));
            else wb_read(a, "R3 random read R4");
            if (i % 20 == 19) begin
                int s;
                @(negedge clk);
                s = int'($urandom_range(1, N_SLOT - 1));
                flip(s, int'($urandom_range(0, 15)));
                push_code();
                check_bus("R6 random upset");
                chk(err_single && !err_multi, "R6 random flags",
                    {err_single, err_multi}, 2'b10);
                do_refresh();
                mdl_set(s, mdl_val[s]);
                chk(!err_single, "R9 random scrub", 32'(err_single), 0);
            end
        end
        check_bus("R2 random final bus R10");

        // R1 reset after traffic
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        for (int k = 0; k < N_SLOT; k++) mdl_set(k, 8'h00);
        check_bus("R1 reset clears");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule